// File: doc/BRIEF.md
# Digital Rate-Trim Second Divider

This block turns a 32.768 kHz oscillator enable into a one-second tick and trims the rate digitally instead of pulling the crystal. The divider is built in two stages. A prescaler of 2^STAGE_LOG2 oscillator enables drives a stage counter, and a second ends after 2^SEC_LOG2 prescaler carries. With the default parameters this is 256 × 128 = 32768 enables. To trim, the block changes the length of one second per minute, in a subset of the minutes of a repeating correction cycle of 2^CYCLE_LOG2 minutes (64 by default). A positive trim drops one prescaler carry, so that second is 256 enables shorter. A negative trim stretches the last prescaler span by half, so that second is 128 enables longer.

An 8-bit control byte is written through a simple write strobe. Bit 7 is the static output level. Bit 6 selects test mode. Bit 5 is the trim direction, where 1 speeds the clock up and 0 slows it down. The low MAG_W bits (at most bits 4:0) hold the trim magnitude. An external minute-boundary strobe advances the correction-cycle index. The block also drives an open-drain test/output pin. In test mode the pin shows a square wave taken from the untrimmed prescaler count. Otherwise it shows the static level bit.

A stop input models a halted oscillator. While it is high, the divider, the test wave and the cycle index all hold their values.

Top module: `calTickGen`

## Requirements
- R1: After reset the control byte reads as 0x80 (static level 1, test mode off, magnitude 0), so the pin is released (pinDriveLow = 0), secTick is low, and the first second is untrimmed.
- R2: A second that is not trimmed lasts exactly 2^(STAGE_LOG2+SEC_LOG2) non-stopped oscTick enables. With magnitude 0 every second is untrimmed.
- R3: A trimmed second with direction bit 5 = 1 lasts 2^STAGE_LOG2 enables less than an untrimmed second.
- R4: A trimmed second with direction bit 5 = 0 lasts 2^(STAGE_LOG2-1) enables more than an untrimmed second.
- R5: The k-th minute strobe after reset opens cycle minute k mod 2^CYCLE_LOG2, counting from 0. The minute is trimmed only when its index is below 2 × magnitude.
- R6: In a trimmed minute exactly one second is changed. It is the second that begins at the first second boundary at or after the minute strobe. A strobe that arrives in the same cycle as a second's final enable therefore trims the second that starts right then.
- R7: The magnitude and direction are sampled at the minute strobe. Writing the control byte between strobes does not change the trim of the minute already open.
- R8: With bit 6 = 1 the pin toggles once every 2^TEST_LOG2 non-stopped enables (512 Hz by default), whatever the trim setting.
- R9: With bit 6 = 0 the pin is pulled low exactly when bit 7 = 0.
- R10: While stopOsc is high, oscTick and minuteStrobe have no effect. The second count, the test wave and the cycle index resume from where they stopped.
- R11: secTick is high only in the clock cycle of a second's final enable, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| oscTick | input | 1 | One-cycle enable at the oscillator rate |
| stopOsc | input | 1 | Halts the divider, test wave and cycle index |
| minuteStrobe | input | 1 | One-cycle minute-boundary strobe |
| ctrlWe | input | 1 | Control byte write enable |
| ctrlWdata | input | 8 | Control byte: [7] level, [6] test, [5] direction, [MAG_W-1:0] magnitude |
| secTick | output | 1 | One-cycle pulse at the end of each second |
| pinDriveLow | output | 1 | 1 pulls the open-drain pin low, 0 releases it |

## Verification
A minute strobe and the end of a second can fall in the same clock cycle. In that case the arming path and the consuming path of the trim logic act together. The bench raises the strobe during the final enable of a second, which it identifies by watching secTick combinationally after driving the enable. It then measures the lengths of the following seconds. The second that starts at that boundary must be the trimmed one, and the next must be untrimmed. A strobe one enable later must instead defer the trim by a full second.

// File: rtl/calTypesPkg.sv
package calTypesPkg;
  // Bit positions of the control byte that the control unit decodes.
  localparam int OutBitPos  = 7;
  localparam int TestBitPos = 6;
  localparam int SignBitPos = 5;

  // Strobes from the control unit into the divider datapath.
  typedef struct packed {
    logic shorten;   // drop one prescaler carry this second
    logic lengthen;  // stretch the last prescaler span by half
    logic testMode;  // pin shows the square wave
    logic outLevel;  // static pin level when not in test mode
  } calStrobe_t;
endpackage

// File: rtl/calSeqCtrl.sv
module calSeqCtrl
  import calTypesPkg::*;
#(
  parameter int CYCLE_LOG2 = 6,
  parameter int MAG_W      = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopOsc,
  input  logic       minuteStrobe,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  input  logic       secEnd,
  output calStrobe_t strobes
);
  localparam logic [7:0] CtrlReset = 8'h80;

  logic [7:0]            ctrlReg;
  logic [CYCLE_LOG2-1:0] minuteIdx;
  logic                  armed, armedSign;
  logic                  active, activeSign;

  logic [MAG_W-1:0]      magNow;
  logic [CYCLE_LOG2-1:0] hitLimit;
  logic                  strobeEff, hit;

  assign magNow    = ctrlReg[MAG_W-1:0];
  assign hitLimit  = CYCLE_LOG2'({magNow, 1'b0});
  assign hit       = minuteIdx < hitLimit;
  assign strobeEff = minuteStrobe & ~stopOsc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CtrlReset;
    end else if (ctrlWe) begin
      ctrlReg <= ctrlWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      minuteIdx <= '0;
    end else if (strobeEff) begin
      minuteIdx <= minuteIdx + 1'b1;
    end
  end

  // Arm on a strobe, consume at the next second boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed      <= 1'b0;
      armedSign  <= 1'b0;
      active     <= 1'b0;
      activeSign <= 1'b0;
    end else if (secEnd) begin
      armed <= 1'b0;
      if (strobeEff) begin
        active     <= hit;
        activeSign <= ctrlReg[SignBitPos];
      end else begin
        active     <= armed;
        activeSign <= armedSign;
      end
    end else if (strobeEff) begin
      armed     <= hit;
      armedSign <= ctrlReg[SignBitPos];
    end
  end

  assign strobes.shorten  = active & activeSign;
  assign strobes.lengthen = active & ~activeSign;
  assign strobes.testMode = ctrlReg[TestBitPos];
  assign strobes.outLevel = ctrlReg[OutBitPos];

  // R5
  minute_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(minuteStrobe && !stopOsc) |=> $stable(minuteIdx));

  // R6
  arm_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secEnd && armed) |=> active);

  // R7
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !secEnd |=> ($stable(active) && $stable(activeSign)));
endmodule

// File: rtl/calDivPath.sv
module calDivPath
  import calTypesPkg::*;
#(
  parameter int STAGE_LOG2 = 8,
  parameter int SEC_LOG2   = 7,
  parameter int TEST_LOG2  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       stopOsc,
  input  calStrobe_t cal,
  output logic       secTick,
  output logic       pinDriveLow
);
  localparam int PRE_W     = STAGE_LOG2 + 1;
  localparam int STAGE     = 1 << STAGE_LOG2;
  localparam int BASE_LIM  = STAGE - 1;
  localparam int EXT_LIM   = STAGE + STAGE / 2 - 1;
  localparam int LAST_NORM = (1 << SEC_LOG2) - 1;
  localparam int LAST_FAST = LAST_NORM - 1;

  logic [PRE_W-1:0]     preCnt;
  logic [SEC_LOG2-1:0]  stageCnt;
  logic [TEST_LOG2-1:0] tstCnt;
  logic                 testWave;

  logic                 advance, isLast, carry;
  logic [PRE_W-1:0]     preLim;

  assign advance = oscTick & ~stopOsc;
  assign isLast  = stageCnt == (cal.shorten ? SEC_LOG2'(LAST_FAST) : SEC_LOG2'(LAST_NORM));
  assign preLim  = (cal.lengthen && isLast) ? PRE_W'(EXT_LIM) : PRE_W'(BASE_LIM);
  assign carry   = advance && (preCnt == preLim);
  assign secTick = carry && isLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      stageCnt <= '0;
    end else if (advance) begin
      if (carry) begin
        preCnt   <= '0;
        stageCnt <= isLast ? '0 : stageCnt + 1'b1;
      end else begin
        preCnt   <= preCnt + 1'b1;
      end
    end
  end

  // Test wave comes from a free count that the trim never touches.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tstCnt   <= '0;
      testWave <= 1'b0;
    end else if (advance) begin
      tstCnt <= tstCnt + 1'b1;
      if (&tstCnt) testWave <= ~testWave;
    end
  end

  assign pinDriveLow = cal.testMode ? ~testWave : ~cal.outLevel;

  // R10
  stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopOsc |=> ($stable(preCnt) && $stable(stageCnt) && $stable(testWave)));

  // R4
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= PRE_W'(EXT_LIM));

  // R8
  wave_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscTick |=> $stable(testWave));

  // R6
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> ($stable(cal.shorten) && $stable(cal.lengthen)));
endmodule

// File: rtl/calTickGen.sv
module calTickGen
  import calTypesPkg::*;
#(
  parameter int STAGE_LOG2 = 8,
  parameter int SEC_LOG2   = 7,
  parameter int CYCLE_LOG2 = 6,
  parameter int MAG_W      = 5,
  parameter int TEST_LOG2  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       stopOsc,
  input  logic       minuteStrobe,
  input  logic       ctrlWe,
  input  logic [7:0] ctrlWdata,
  output logic       secTick,
  output logic       pinDriveLow
);
  calStrobe_t strobes;

  calSeqCtrl #(.CYCLE_LOG2(CYCLE_LOG2), .MAG_W(MAG_W)) uCtrl (
    .clk(clk), .rstN(rstN), .stopOsc(stopOsc), .minuteStrobe(minuteStrobe),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .secEnd(secTick), .strobes(strobes)
  );

  calDivPath #(.STAGE_LOG2(STAGE_LOG2), .SEC_LOG2(SEC_LOG2), .TEST_LOG2(TEST_LOG2)) uPath (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .stopOsc(stopOsc), .cal(strobes),
    .secTick(secTick), .pinDriveLow(pinDriveLow)
  );
endmodule

// File: tb/tb_calTickGen.sv
module tb_calTickGen;
  localparam int SL = 3, SQ = 2, CL = 3, MW = 2, TL = 2;
  localparam int NORM   = 1 << (SL + SQ);
  localparam int FAST   = NORM - (1 << SL);
  localparam int SLOW   = NORM + (1 << (SL - 1));
  localparam int TOGGLE = 1 << TL;
  localparam int MINS   = 1 << CL;

  logic clk = 0, rstN = 0, oscTick = 0, stopOsc = 0, minuteStrobe = 0, ctrlWe = 0;
  logic [7:0] ctrlWdata = '0;
  logic secTick, pinDriveLow;

  int checks = 0, fails = 0;
  int stepIdx = 0, lastEdge = -1;
  bit watchPin = 0, pinPrev = 0;

  calTickGen #(.STAGE_LOG2(SL), .SEC_LOG2(SQ), .CYCLE_LOG2(CL), .MAG_W(MW), .TEST_LOG2(TL)) dut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .stopOsc(stopOsc), .minuteStrobe(minuteStrobe),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .secTick(secTick), .pinDriveLow(pinDriveLow)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic watchPinEdge();
    bit pinNow;
    pinNow = pinDriveLow;
    if (watchPin && pinNow != pinPrev) begin
      if (lastEdge >= 0) check("R8 toggle interval", stepIdx - lastEdge, TOGGLE);
      lastEdge = stepIdx;
    end
    pinPrev = pinNow;
  endtask

  task automatic oscStep(input bit strbAny, input bit strbOnTick, output bit tk);
    @(negedge clk);
    watchPinEdge();
    oscTick = 1; minuteStrobe = strbAny;
    #1;
    tk = secTick;
    if (tk && strbOnTick) minuteStrobe = 1;
    stepIdx++;
    @(negedge clk);
    oscTick = 0; minuteStrobe = 0;
    if (tk) check("R11 pulse width", int'(secTick), 0);
  endtask

  task automatic stopStep();
    @(negedge clk);
    stopOsc = 1; oscTick = 1; minuteStrobe = 1;
    #1;
    check("R10 no tick when stopped", int'(secTick), 0);
    @(negedge clk);
    oscTick = 0; minuteStrobe = 0;
    if (watchPin) check("R10 pin frozen", int'(pinDriveLow), int'(pinPrev));
  endtask

  task automatic runSecond(input bit strbFirst, input bit strbOnTick, output int len);
    bit tk;
    len = 0;
    do begin
      oscStep(strbFirst && (len == 0), strbOnTick, tk);
      len++;
    end while (!tk && len < 200);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; oscTick = 0; stopOsc = 0; minuteStrobe = 0; ctrlWe = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    watchPin = 0; stepIdx = 0; lastEdge = -1;
  endtask

  task automatic writeCtrl(input logic [7:0] d);
    @(negedge clk);
    ctrlWe = 1; ctrlWdata = d;
    @(negedge clk);
    ctrlWe = 0;
  endtask

  task automatic startWatch();
    watchPin = 1; pinPrev = pinDriveLow; lastEdge = -1;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int len, exp;
    // R1 reset state
    doReset();
    @(negedge clk);
    check("R1 pin released", int'(pinDriveLow), 0);
    check("R1 no tick", int'(secTick), 0);
    runSecond(0, 0, len);
    check("R1 first second untrimmed", len, NORM);

    // R9 static pin level
    writeCtrl(8'h00);
    check("R9 level 0 pulls low", int'(pinDriveLow), 1);
    writeCtrl(8'h80);
    check("R9 level 1 releases", int'(pinDriveLow), 0);

    // Sweep magnitude and direction over a full correction cycle (R2 R3 R4 R5 R8)
    for (int mag = 0; mag < (1 << MW); mag++) begin
      for (int sgn = 0; sgn < 2; sgn++) begin
        doReset();
        writeCtrl(8'h40 | 8'(sgn << 5) | 8'(mag));
        startWatch();
        runSecond(0, 0, len);
        check("R2 lead second", len, NORM);
        for (int m = 0; m < MINS + 2; m++) begin
          runSecond(1, 0, len);
          check("R5 strobe second untrimmed", len, NORM);
          runSecond(0, 0, len);
          if ((m % MINS) < 2 * mag) begin
            exp = sgn ? FAST : SLOW;
            if (sgn) check("R3 shortened second", len, exp);
            else     check("R4 lengthened second", len, exp);
          end else begin
            check("R2 untrimmed minute", len, NORM);
          end
          runSecond(0, 0, len);
          check("R6 one trim per minute", len, NORM);
        end
        watchPin = 0;
      end
    end

    // R6 strobe in the same cycle as a second end
    doReset();
    writeCtrl(8'hA1);
    runSecond(0, 1, len);
    check("R6 coincident lead", len, NORM);
    runSecond(0, 0, len);
    check("R6 coincident trims next second", len, FAST);
    runSecond(0, 0, len);
    check("R6 only one trimmed", len, NORM);
    runSecond(0, 1, len);
    check("R6 second before minute 1", len, NORM);
    runSecond(0, 1, len);
    check("R6 minute 1 trimmed", len, FAST);
    runSecond(0, 0, len);
    check("R5 minute 2 not trimmed", len, NORM);

    // R7 magnitude change takes effect at next strobe
    doReset();
    writeCtrl(8'hA0);
    runSecond(0, 0, len);
    runSecond(1, 0, len);
    writeCtrl(8'hA1);
    runSecond(0, 0, len);
    check("R7 mid-minute write ignored", len, NORM);
    runSecond(1, 0, len);
    runSecond(0, 0, len);
    check("R7 applied after strobe", len, FAST);

    // R7 direction sampled at strobe
    doReset();
    writeCtrl(8'hA1);
    runSecond(0, 0, len);
    runSecond(1, 0, len);
    writeCtrl(8'h81);
    runSecond(0, 0, len);
    check("R7 direction from strobe time", len, FAST);

    // R10 stop freezes divider, test wave and cycle index
    doReset();
    writeCtrl(8'hC0);
    startWatch();
    runSecond(0, 0, len);
    for (int i = 0; i < 10; i++) begin
      bit tk;
      oscStep(0, 0, tk);
      if (tk) check("R10 early tick", 1, 0);
    end
    for (int i = 0; i < 20; i++) stopStep();
    @(negedge clk);
    stopOsc = 0;
    runSecond(0, 0, len);
    check("R10 second resumes", len + 10, NORM);
    writeCtrl(8'hE1);
    runSecond(1, 0, len);
    runSecond(0, 0, len);
    check("R10 strobes while stopped ignored", len, FAST);
    watchPin = 0;

    finishRun();
  end
endmodule